// File: doc/BRIEF.md
# Safety Error Status Aggregator

The aggregator gathers one-cycle error pulses raised by three protection domains and holds them in three 32-bit sticky status registers. The first domain covers datapath parity and state-machine timeout faults of the MAC. The second covers ECC faults of four queue-side memories: transmit, receive, scheduling list and parser. The third covers ECC faults of the DMA segmentation memory. Once a bit is captured it stays set until software clears it. Software clears a bit by writing a one to it, so writing back a value it has just read clears exactly the events it has seen.

Five summary interrupt lines are formed from the captured state. Every MAC-domain fault counts as uncorrectable. Each ECC domain splits its faults into a correctable class and an uncorrectable class, and the address-mismatch faults fall in the uncorrectable class. Correctable summaries are gated per memory by enable registers, and uncorrectable summaries are never gated. Bit positions with no assigned fault are hard-wired to zero.

Top module: `safety_err_agg`

## Requirements
- R1: While rst_n is low at a rising edge, every status register and enable register is cleared, even if pulses are present, and all five interrupt outputs are low after that edge.
- R2: A pulse on a defined status bit sets that bit at the next rising edge, and the bit stays set for as long as no clear write targets it.
- R3: A write to a status register (reg_sel 0 = MAC, 1 = memory ECC, 2 = DMA ECC) clears exactly the bits where reg_wdata is one. Bits where reg_wdata is zero keep their value.
- R4: When a pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: Reserved bits always read zero and ignore both pulses and write data. In the MAC domain the reserved bits are 20–23 and 25–31. In the memory domain they are 3, 7, 11 and 15–31. In the DMA domain they are 3–31.
- R6: irq_mac_unc is high exactly when any MAC status bit is set, and no enable affects it.
- R7: The memory-domain correctable bits are 0 (TX), 4 (RX), 8 (scheduling list) and 12 (parser). Their enables are bits 0, 1, 2 and 3 of register 3. irq_mem_cor is high exactly when some correctable bit is set and its enable is one.
- R8: The memory-domain uncorrectable bits are address mismatch (1, 5, 9, 13) and uncorrectable (2, 6, 10, 14). irq_mem_unc is high exactly when any of these bits is set, regardless of enables.
- R9: In the DMA domain, bit 0 is correctable, bit 1 is address mismatch and bit 2 is uncorrectable. irq_dma_cor equals bit 0 AND bit 0 of register 4. irq_dma_unc equals bit 1 OR bit 2.
- R10: Registers 3 and 4 are plain read/write registers holding 4 and 1 bits, and their upper bits read zero. reg_sel values 5–7 read zero, and writes to them change nothing.
- R11: Status capture does not depend on the enables. A correctable event with its enable off is still recorded, and the summary rises in the same cycle its enable is written on.
- R12: reg_rdata is combinational from reg_sel. Summaries follow status with no added register, so a summary falls on the edge that clears its last contributing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mac_err_pulse | input | 32 | MAC-domain one-cycle error pulses |
| mem_err_pulse | input | 32 | Memory-ECC-domain one-cycle error pulses |
| dma_err_pulse | input | 32 | DMA-ECC-domain one-cycle error pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data (ones clear status bits) |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_mac_unc | output | 1 | MAC uncorrectable summary |
| irq_mem_cor | output | 1 | Memory correctable summary |
| irq_mem_unc | output | 1 | Memory uncorrectable summary |
| irq_dma_cor | output | 1 | DMA correctable summary |
| irq_dma_unc | output | 1 | DMA uncorrectable summary |

## Verification
The hardest case to reach from the ports is a clear that lands on a bit in the very cycle a new pulse reaches it. Random stimulus seldom lines these up on the same bit. A directed step therefore drives an all-ones clear together with a chosen pulse pattern in one cycle. The random phase is also biased to reuse the same bit positions for pulses and write data. A second corner is a correctable event recorded while its enable is off: the bench confirms the status bit is captured and the summary stays low, then turns the enable on and sees the summary rise without any new event.

// File: rtl/sea_pkg.sv
// sea_pkg: shared constants of the safety error status aggregator.
// Assumes 32-bit status words and three-bit register select codes.
package sea_pkg;
    localparam int DW         = 32;
    localparam int SELW       = 3;
    localparam int ECC_STRIDE = 4;   // bits per memory group in an ECC domain
    localparam int MEM_GROUPS = 4;
    localparam int DMA_GROUPS = 1;

    localparam logic [SELW-1:0] ADDR_MAC    = 3'd0;
    localparam logic [SELW-1:0] ADDR_MEM    = 3'd1;
    localparam logic [SELW-1:0] ADDR_DMA    = 3'd2;
    localparam logic [SELW-1:0] ADDR_MEM_EN = 3'd3;
    localparam logic [SELW-1:0] ADDR_DMA_EN = 3'd4;

    // Defined-bit masks: group layout is {reserved, unc, mismatch, cor}
    function automatic logic [DW-1:0] ecc_valid(input int groups);
        logic [DW-1:0] m;
        m = '0;
        for (int g = 0; g < groups; g++) m[g*ECC_STRIDE +: 3] = 3'b111;
        return m;
    endfunction

    localparam logic [DW-1:0] MAC_VALID = 32'h010F_FFFF;
    localparam logic [DW-1:0] MEM_VALID = ecc_valid(MEM_GROUPS);
    localparam logic [DW-1:0] DMA_VALID = ecc_valid(DMA_GROUPS);
endpackage

// File: rtl/sea_status_reg.sv
// sea_status_reg: sticky status word with write-one-to-clear.
// Set has priority over clear; bits outside VALID are constant zero.
module sea_status_reg #(
    parameter int            W     = 32,
    parameter logic [W-1:0]  VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] clr_mask;
    logic [W-1:0] stat_q;

    // Purpose: select which bits the current write clears
    always_comb begin
        clr_mask = clr_en_i ? clr_data_i : '0;
    end

    // Purpose: hold captured events, clear on request, new events win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_mask) | set_i) & VALID;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/sea_enable_reg.sv
// sea_enable_reg: plain read/write enable bits loaded from write data.
// Assumes the caller qualifies we_i with the register select.
module sea_enable_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Purpose: store enables, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (we_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/sea_ecc_sum.sv
// sea_ecc_sum: summary generation for one ECC domain.
// Inputs are already separated per group: one correctable bit and
// two uncorrectable-class bits (mismatch, uncorrectable) per memory.
module sea_ecc_sum #(
    parameter int GROUPS = 4
) (
    input  logic [GROUPS-1:0]   cor_i,
    input  logic [2*GROUPS-1:0] unc_i,
    input  logic [GROUPS-1:0]   en_i,
    output logic                cor_o,
    output logic                unc_o
);
    // Purpose: correctable events only count when their memory is enabled
    always_comb begin
        cor_o = |(cor_i & en_i);
    end

    // Purpose: uncorrectable-class events are never masked
    always_comb begin
        unc_o = |unc_i;
    end
endmodule

// File: rtl/safety_err_agg.sv
// safety_err_agg: sticky capture of three safety domains, register
// port with write-one-to-clear, enables and five summary interrupts.
// Assumes error pulses are synchronous to clk and one cycle wide.
module safety_err_agg
    import sea_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   mac_err_pulse,
    input  logic [DW-1:0]   mem_err_pulse,
    input  logic [DW-1:0]   dma_err_pulse,
    input  logic            reg_wr,
    input  logic [SELW-1:0] reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq_mac_unc,
    output logic            irq_mem_cor,
    output logic            irq_mem_unc,
    output logic            irq_dma_cor,
    output logic            irq_dma_unc
);
    logic [DW-1:0]         mac_stat, mem_stat, dma_stat;
    logic [MEM_GROUPS-1:0] mem_en;
    logic [DMA_GROUPS-1:0] dma_en;
    logic wr_mac, wr_mem, wr_dma, wr_mem_en, wr_dma_en;

    logic [MEM_GROUPS-1:0]   mem_cor;
    logic [2*MEM_GROUPS-1:0] mem_unc;
    logic [DMA_GROUPS-1:0]   dma_cor;
    logic [2*DMA_GROUPS-1:0] dma_unc;

    // Purpose: decode write strobes per register
    always_comb begin
        wr_mac    = reg_wr && (reg_sel == ADDR_MAC);
        wr_mem    = reg_wr && (reg_sel == ADDR_MEM);
        wr_dma    = reg_wr && (reg_sel == ADDR_DMA);
        wr_mem_en = reg_wr && (reg_sel == ADDR_MEM_EN);
        wr_dma_en = reg_wr && (reg_sel == ADDR_DMA_EN);
    end

    sea_status_reg #(.W(DW), .VALID(MAC_VALID)) u_mac_stat (
        .clk(clk), .rst_n(rst_n), .set_i(mac_err_pulse),
        .clr_en_i(wr_mac), .clr_data_i(reg_wdata), .stat_o(mac_stat));

    sea_status_reg #(.W(DW), .VALID(MEM_VALID)) u_mem_stat (
        .clk(clk), .rst_n(rst_n), .set_i(mem_err_pulse),
        .clr_en_i(wr_mem), .clr_data_i(reg_wdata), .stat_o(mem_stat));

    sea_status_reg #(.W(DW), .VALID(DMA_VALID)) u_dma_stat (
        .clk(clk), .rst_n(rst_n), .set_i(dma_err_pulse),
        .clr_en_i(wr_dma), .clr_data_i(reg_wdata), .stat_o(dma_stat));

    sea_enable_reg #(.W(MEM_GROUPS)) u_mem_en (
        .clk(clk), .rst_n(rst_n), .we_i(wr_mem_en),
        .d_i(reg_wdata[MEM_GROUPS-1:0]), .q_o(mem_en));

    sea_enable_reg #(.W(DMA_GROUPS)) u_dma_en (
        .clk(clk), .rst_n(rst_n), .we_i(wr_dma_en),
        .d_i(reg_wdata[DMA_GROUPS-1:0]), .q_o(dma_en));

    // Split each ECC group into its correctable and uncorrectable-class bits
    for (genvar g = 0; g < MEM_GROUPS; g++) begin : g_mem_split
        assign mem_cor[g]       = mem_stat[g*ECC_STRIDE];
        assign mem_unc[2*g +: 2] = mem_stat[g*ECC_STRIDE+1 +: 2];
    end
    for (genvar g = 0; g < DMA_GROUPS; g++) begin : g_dma_split
        assign dma_cor[g]       = dma_stat[g*ECC_STRIDE];
        assign dma_unc[2*g +: 2] = dma_stat[g*ECC_STRIDE+1 +: 2];
    end

    sea_ecc_sum #(.GROUPS(MEM_GROUPS)) u_mem_sum (
        .cor_i(mem_cor), .unc_i(mem_unc), .en_i(mem_en),
        .cor_o(irq_mem_cor), .unc_o(irq_mem_unc));

    sea_ecc_sum #(.GROUPS(DMA_GROUPS)) u_dma_sum (
        .cor_i(dma_cor), .unc_i(dma_unc), .en_i(dma_en),
        .cor_o(irq_dma_cor), .unc_o(irq_dma_unc));

    // Purpose: every MAC-domain fault is uncorrectable and ungated
    always_comb begin
        irq_mac_unc = |mac_stat;
    end

    // Purpose: combinational read mux, unmapped selects read zero
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            ADDR_MAC:    reg_rdata = mac_stat;
            ADDR_MEM:    reg_rdata = mem_stat;
            ADDR_DMA:    reg_rdata = dma_stat;
            ADDR_MEM_EN: reg_rdata[MEM_GROUPS-1:0] = mem_en;
            ADDR_DMA_EN: reg_rdata[DMA_GROUPS-1:0] = dma_en;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sea_checker.sv
// sea_checker: temporal properties of safety_err_agg, bound to the top.
module sea_checker
    import sea_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [DW-1:0]   mac_err_pulse,
    input logic [DW-1:0]   dma_err_pulse,
    input logic            reg_wr,
    input logic [SELW-1:0] reg_sel,
    input logic [DW-1:0]   reg_wdata,
    input logic [DW-1:0]   mac_stat,
    input logic [DW-1:0]   mem_stat,
    input logic [DW-1:0]   dma_stat,
    input logic [MEM_GROUPS-1:0] mem_en,
    input logic            irq_mac_unc,
    input logic            irq_mem_cor,
    input logic            irq_dma_unc
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((mac_stat & ~MAC_VALID) == '0) && ((mem_stat & ~MEM_VALID) == '0) && ((dma_stat & ~DMA_VALID) == '0)); // R5

    AST_MAC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == ADDR_MAC) |=> ((mac_stat & $past(mac_stat)) == $past(mac_stat))); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mac_err_pulse & MAC_VALID) != '0) |=>
        ((mac_stat & $past(mac_err_pulse & MAC_VALID)) == $past(mac_err_pulse & MAC_VALID))); // R4

    AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == ADDR_DMA && dma_err_pulse == '0) |=> ((dma_stat & $past(reg_wdata)) == '0)); // R3

    AST_MAC_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mac_unc == (mac_stat != '0)); // R6

    AST_MEM_COR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mem_cor |-> (mem_en != '0)); // R7

    AST_DMA_UNC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dma_unc == (dma_stat[2:1] != 2'b00)); // R9
endmodule

bind safety_err_agg sea_checker u_sea_checker (.*);

// File: tb/sim_safety_err_agg.sv
`timescale 1ns/1ps
module sim_safety_err_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mac_err_pulse = '0, mem_err_pulse = '0, dma_err_pulse = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq_mac_unc, irq_mem_cor, irq_mem_unc, irq_dma_cor, irq_dma_unc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] M_MAC = 32'h010F_FFFF;
    localparam logic [31:0] M_MEM = 32'h0000_7777;
    localparam logic [31:0] M_DMA = 32'h0000_0007;

    logic [31:0] e_mac = '0, e_mem = '0, e_dma = '0;
    logic [3:0]  e_men = '0;
    logic        e_den = 1'b0;

    always #2.5 clk = ~clk;

    safety_err_agg u0 (
        .clk(clk), .rst_n(rst_n), .mac_err_pulse(mac_err_pulse),
        .mem_err_pulse(mem_err_pulse), .dma_err_pulse(dma_err_pulse),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_mac_unc(irq_mac_unc),
        .irq_mem_cor(irq_mem_cor), .irq_mem_unc(irq_mem_unc),
        .irq_dma_cor(irq_dma_cor), .irq_dma_unc(irq_dma_unc));

    function automatic logic [31:0] nxt(input logic [31:0] s, input logic [31:0] p,
                                        input logic [31:0] c, input logic [31:0] m);
        return ((s & ~c) | p) & m;
    endfunction

    function automatic logic f_mem_cor(input logic [31:0] s, input logic [3:0] en);
        return (s[0] & en[0]) | (s[4] & en[1]) | (s[8] & en[2]) | (s[12] & en[3]);
    endfunction

    function automatic logic f_mem_unc(input logic [31:0] s);
        return |(s & 32'h0000_6666);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R6 irq_mac_unc"}, {31'd0, irq_mac_unc}, {31'd0, e_mac != 0});
        chk({tag, " R7 irq_mem_cor"}, {31'd0, irq_mem_cor}, {31'd0, f_mem_cor(e_mem, e_men)});
        chk({tag, " R8 irq_mem_unc"}, {31'd0, irq_mem_unc}, {31'd0, f_mem_unc(e_mem)});
        chk({tag, " R9 irq_dma_cor"}, {31'd0, irq_dma_cor}, {31'd0, e_dma[0] & e_den});
        chk({tag, " R9 irq_dma_unc"}, {31'd0, irq_dma_unc}, {31'd0, |e_dma[2:1]});
        for (int a = 0; a < 8; a++) begin
            logic [31:0] ev;
            case (a)
                0: ev = e_mac;
                1: ev = e_mem;
                2: ev = e_dma;
                3: ev = {28'd0, e_men};
                4: ev = {31'd0, e_den};
                default: ev = '0;
            endcase
            reg_sel = 3'(a);
            #0.25;
            chk({tag, " R2 R3 R10 R12 readback"}, reg_rdata, ev);
        end
    endtask

    // One clock: drive at negedge, update model at the edge, check next negedge
    task automatic cyc(input logic [31:0] mp, input logic [31:0] mep, input logic [31:0] dp,
                       input logic wr, input logic [2:0] sel, input logic [31:0] wd,
                       input string tag);
        mac_err_pulse = mp; mem_err_pulse = mep; dma_err_pulse = dp;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        if (!rst_n) begin
            e_mac = '0; e_mem = '0; e_dma = '0; e_men = '0; e_den = 1'b0;
        end else begin
            e_mac = nxt(e_mac, mp,  (wr && sel == 3'd0) ? wd : '0, M_MAC);
            e_mem = nxt(e_mem, mep, (wr && sel == 3'd1) ? wd : '0, M_MEM);
            e_dma = nxt(e_dma, dp,  (wr && sel == 3'd2) ? wd : '0, M_DMA);
            if (wr && sel == 3'd3) e_men = wd[3:0];
            if (wr && sel == 3'd4) e_den = wd[0];
        end
        @(negedge clk);
        mac_err_pulse = '0; mem_err_pulse = '0; dma_err_pulse = '0;
        reg_wr = 1'b0; reg_wdata = '0;
        check_all(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: pulses and writes during reset are discarded
        cyc('1, '1, '1, 1'b1, 3'd3, '1, "R1");
        cyc('1, '1, '1, 1'b1, 3'd4, '1, "R1");
        rst_n = 1'b1;
        cyc('0, '0, '0, 1'b0, 3'd0, '0, "R1");

        // R5: all-ones pulses and writes only reach defined bits
        cyc('1, '1, '1, 1'b0, 3'd0, '0, "R5");
        chk("R5 mac reserved", e_mac, 32'h010F_FFFF);
        cyc('0, '0, '0, 1'b1, 3'd0, 32'h0000_00F0, "R3");
        cyc('0, '0, '0, 1'b1, 3'd1, '1, "R3");
        cyc('0, '0, '0, 1'b1, 3'd2, 32'h0000_0004, "R3");
        cyc('0, '0, '0, 1'b1, 3'd0, '1, "R6");
        cyc('0, '0, '0, 1'b1, 3'd2, '1, "R9");

        // R11: correctable event with enable off is captured, summary waits
        cyc('0, 32'h0000_0100, 32'h1, 1'b0, 3'd0, '0, "R11");
        chk("R11 irq_mem_cor low", {31'd0, irq_mem_cor}, 32'd0);
        cyc('0, '0, '0, 1'b1, 3'd3, 32'hFFFF_FFF4, "R11");
        chk("R11 irq_mem_cor high", {31'd0, irq_mem_cor}, 32'd1);
        cyc('0, '0, '0, 1'b1, 3'd4, 32'hFFFF_FFFF, "R11");
        chk("R11 irq_dma_cor high", {31'd0, irq_dma_cor}, 32'd1);
        // R10: unmapped select write has no effect
        cyc('0, '0, '0, 1'b1, 3'd6, '1, "R10");
        cyc('0, '0, '0, 1'b1, 3'd1, 32'h0000_0100, "R12");
        chk("R12 irq_mem_cor falls", {31'd0, irq_mem_cor}, 32'd0);

        // R4: clear and pulse collide on the same bits
        cyc(32'h0100_0003, '0, '0, 1'b0, 3'd0, '0, "R4");
        cyc(32'h0000_0001, '0, '0, 1'b1, 3'd0, '1, "R4");
        chk("R4 set wins", e_mac, 32'h0000_0001);
        cyc('0, 32'h0000_2000, '0, 1'b1, 3'd1, 32'h0000_2000, "R4");
        cyc('0, '0, 32'h2, 1'b1, 3'd2, 32'h2, "R4");

        // Random phase, pulses sparse and write data aimed at the same bits
        for (int i = 0; i < 400; i++) begin
            logic [31:0] mp, mep, dp, wd;
            logic wr;
            logic [2:0] sel;
            mp  = $urandom & $urandom & $urandom;
            mep = $urandom & $urandom & $urandom;
            dp  = $urandom & $urandom;
            wr  = ($urandom % 3) != 0;
            sel = 3'($urandom % 8);
            case ($urandom % 3)
                0: wd = $urandom;
                1: wd = (sel == 3'd0) ? mp : (sel == 3'd1) ? mep : dp;
                default: wd = '1;
            endcase
            if (($urandom % 8) == 0) mp = '0;
            cyc(mp, mep, dp, wr, sel, wd, "RND");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule